// File: doc/BRIEF.md
# Word-to-Byte Data Buffer

This block sits between a host register port that moves 16-bit words and a serial engine that moves one byte at a time. It holds up to four bytes in a single 32-bit store. A host write loads two bytes at once and a host read takes up to two bytes at once. On the engine side, transmit bytes leave one per pop and receive bytes arrive one per push. Transmit and receive each keep their own occupancy count. Both directions share the same store.

A byte-order input sets how the two bytes of a host word map onto the store. The same setting applies to writes and to reads. The block drives five flags toward a status unit: transmit underflow, transmit ready, receive overrun, receive ready, and single-byte read. A low `enable` clears the counts, the store and the flags, just as reset does. The serial bus protocol is outside this block.

Top module: `wordbyte_buffer`

## Requirements
- R1: After reset, and on any cycle after `enable` was low, both counts are 0, every flag is 0 and the store holds zero, so a host read returns 0.
- R2: A host write taken while `tx_count` is 2 or less shifts the store left by 16 bits, places the new word in bits 15:0 and adds 2 to `tx_count`. A write while `tx_count` is 3 or 4 changes nothing.
- R3: With `big_endian` at 0, a written word's bits 7:0 go to store bits 15:8 and its bits 15:8 go to store bits 7:0. With `big_endian` at 1, the word is stored as written.
- R4: An accepted host write clears `tx_underflow`. It also clears `tx_ready` when the new `tx_count` is above 2.
- R5: `eng_tx_byte` shows store byte index `tx_count`-1, where index 0 is bits 7:0. It shows 0 when `tx_count` is 0. A pop lowers `tx_count` by 1. A pop at count 0 sets `tx_underflow` and leaves the count at 0.
- R6: Every engine pop sets `tx_ready`.
- R7: A push writes `eng_rx_byte` into store byte index `rx_count` and adds 1 to the count. A push at count 4 leaves the store and the count unchanged and sets `rx_overrun`. Every push sets `rx_ready`.
- R8: `host_rdata` shows store bits 15:0 unchanged when `big_endian` is 0. When it is 1, the two bytes of store bits 15:0 are swapped.
- R9: A host read at `rx_count` 1 sets `single_byte` and makes the count 0. A read at a count above 1 lowers it by 2, and also shifts the store right by 16 bits when the count was above 2.
- R10: Every host read clears `rx_overrun`. A host read that leaves `rx_count` at 0 clears `rx_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Block enable; low clears all state |
| big_endian | input | 1 | Host word byte order select |
| host_wr | input | 1 | Host word write strobe |
| host_wdata | input | 16 | Host write word |
| host_rd | input | 1 | Host word read strobe |
| host_rdata | output | 16 | Host read word (combinational) |
| eng_tx_pop | input | 1 | Engine takes one transmit byte |
| eng_tx_byte | output | 8 | Byte offered to the engine |
| eng_rx_push | input | 1 | Engine delivers one receive byte |
| eng_rx_byte | input | 8 | Received byte |
| tx_count | output | 3 | Transmit bytes held |
| rx_count | output | 3 | Receive bytes held |
| tx_underflow | output | 1 | Pop found no transmit byte |
| tx_ready | output | 1 | Transmit side wants data |
| rx_overrun | output | 1 | Push found the store full |
| rx_ready | output | 1 | Receive data available |
| single_byte | output | 1 | A read consumed only one byte |

## Verification
The assertions assume that at most one of the four strobes is high in a cycle. The block handles overlapping strobes by a fixed priority: write, then read, then pop, then push. Each property applies only to cycles where the strobe it checks is the only one high and `enable` is high. The stimulus follows this assumption: it raises exactly one strobe, or none, per cycle. It also drops `enable` and flips `big_endian` between operations, so the properties still cover the clear behaviour and both byte orders.

// File: rtl/wordbyte_buffer.sv
module wordbyte_buffer #(
  parameter int BYTES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic        big_endian,
  input  logic        host_wr,
  input  logic [15:0] host_wdata,
  input  logic        host_rd,
  output logic [15:0] host_rdata,
  input  logic        eng_tx_pop,
  output logic [7:0]  eng_tx_byte,
  input  logic        eng_rx_push,
  input  logic [7:0]  eng_rx_byte,
  output logic [2:0]  tx_count,
  output logic [2:0]  rx_count,
  output logic        tx_underflow,
  output logic        tx_ready,
  output logic        rx_overrun,
  output logic        rx_ready,
  output logic        single_byte
);
  localparam int W = 8 * BYTES;
  localparam logic [2:0] FULL = 3'(BYTES);
  localparam logic [2:0] WR_LIMIT = 3'(BYTES - 2);

  logic [W-1:0] store;
  logic [W-1:0] tx_sel;
  logic [W-1:0] rx_mask, rx_ins;
  logic [15:0]  wword;
  logic [2:0]   tx_idx;

  assign wword  = big_endian ? host_wdata : {host_wdata[7:0], host_wdata[15:8]};
  assign host_rdata = big_endian ? {store[7:0], store[15:8]} : store[15:0];

  assign tx_idx = tx_count - 3'd1;
  assign tx_sel = store >> {tx_idx, 3'b000};
  assign eng_tx_byte = (tx_count == 3'd0) ? 8'h00 : tx_sel[7:0];

  assign rx_mask = W'(8'hFF) << {rx_count, 3'b000};
  assign rx_ins  = W'(eng_rx_byte) << {rx_count, 3'b000};

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      store        <= '0;
      tx_count     <= '0;
      rx_count     <= '0;
      tx_underflow <= 1'b0;
      tx_ready     <= 1'b0;
      rx_overrun   <= 1'b0;
      rx_ready     <= 1'b0;
      single_byte  <= 1'b0;
    end else if (host_wr) begin
      if (tx_count <= WR_LIMIT) begin
        store        <= {store[W-17:0], wword};
        tx_count     <= tx_count + 3'd2;
        tx_underflow <= 1'b0;
        if (tx_count != 3'd0) tx_ready <= 1'b0;
      end
    end else if (host_rd) begin
      rx_overrun <= 1'b0;
      if (rx_count == 3'd1) begin
        single_byte <= 1'b1;
        rx_count    <= 3'd0;
        rx_ready    <= 1'b0;
      end else if (rx_count > 3'd1) begin
        if (rx_count > 3'd2) store <= store >> 16;
        rx_count <= rx_count - 3'd2;
        if (rx_count == 3'd2) rx_ready <= 1'b0;
      end else begin
        rx_ready <= 1'b0;
      end
    end else if (eng_tx_pop) begin
      tx_ready <= 1'b1;
      if (tx_count == 3'd0) tx_underflow <= 1'b1;
      else tx_count <= tx_count - 3'd1;
    end else if (eng_rx_push) begin
      rx_ready <= 1'b1;
      if (rx_count == FULL) begin
        rx_overrun <= 1'b1;
      end else begin
        store    <= (store & ~rx_mask) | rx_ins;
        rx_count <= rx_count + 3'd1;
      end
    end
  end
endmodule

// File: rtl/wordbyte_buffer_checker.sv
module wordbyte_buffer_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       host_wr,
  input logic       host_rd,
  input logic       eng_tx_pop,
  input logic       eng_rx_push,
  input logic [2:0] tx_count,
  input logic [2:0] rx_count,
  input logic       tx_underflow,
  input logic       tx_ready,
  input logic       rx_overrun,
  input logic       rx_ready,
  input logic       single_byte
);
  logic only_wr, only_rd, only_pop, only_push;
  assign only_wr   = enable && host_wr && !host_rd && !eng_tx_pop && !eng_rx_push;
  assign only_rd   = enable && host_rd && !host_wr && !eng_tx_pop && !eng_rx_push;
  assign only_pop  = enable && eng_tx_pop && !host_wr && !host_rd && !eng_rx_push;
  assign only_push = enable && eng_rx_push && !host_wr && !host_rd && !eng_tx_pop;

  a_r1_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (tx_count == 3'd0 && rx_count == 3'd0 && !tx_underflow && !rx_overrun && !single_byte));

  a_r2_full_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (only_wr && tx_count > 3'd2) |=> $stable(tx_count));

  a_r2_counts_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count <= 3'd4 && rx_count <= 3'd4));

  a_r5_empty_pop_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (only_pop && tx_count == 3'd0) |=> (tx_underflow && tx_count == 3'd0));

  a_r6_pop_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
    only_pop |=> tx_ready);

  a_r7_full_push_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (only_push && rx_count == 3'd4) |=> (rx_overrun && rx_ready && rx_count == 3'd4));

  a_r9_single_byte_read: assert property (@(posedge clk) disable iff (!rst_n)
    (only_rd && rx_count == 3'd1) |=> (single_byte && rx_count == 3'd0));

  a_r10_read_clears_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    only_rd |=> !rx_overrun);
endmodule

bind wordbyte_buffer wordbyte_buffer_checker u_checker (
  .clk(clk), .rst_n(rst_n), .enable(enable),
  .host_wr(host_wr), .host_rd(host_rd), .eng_tx_pop(eng_tx_pop), .eng_rx_push(eng_rx_push),
  .tx_count(tx_count), .rx_count(rx_count), .tx_underflow(tx_underflow), .tx_ready(tx_ready),
  .rx_overrun(rx_overrun), .rx_ready(rx_ready), .single_byte(single_byte)
);

// File: tb/wordbyte_buffer_bench.sv
module wordbyte_buffer_bench;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0, enable = 1'b0, big_endian = 1'b0;
  logic host_wr = 1'b0, host_rd = 1'b0, eng_tx_pop = 1'b0, eng_rx_push = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [7:0]  eng_rx_byte = '0;
  logic [15:0] host_rdata;
  logic [7:0]  eng_tx_byte;
  logic [2:0]  tx_count, rx_count;
  logic tx_underflow, tx_ready, rx_overrun, rx_ready, single_byte;

  wordbyte_buffer u_wordbyte_buffer (
    .clk(clk), .rst_n(rst_n), .enable(enable), .big_endian(big_endian),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
    .eng_tx_pop(eng_tx_pop), .eng_tx_byte(eng_tx_byte),
    .eng_rx_push(eng_rx_push), .eng_rx_byte(eng_rx_byte),
    .tx_count(tx_count), .rx_count(rx_count), .tx_underflow(tx_underflow), .tx_ready(tx_ready),
    .rx_overrun(rx_overrun), .rx_ready(rx_ready), .single_byte(single_byte)
  );

  always #(PERIOD/2) clk = ~clk;

  int vectors = 0, miscompares = 0;
  bit finished = 0;

  logic [7:0] mb [4];
  int m_tx = 0, m_rx = 0;
  bit m_udf = 0, m_trdy = 0, m_ovr = 0, m_rrdy = 0, m_sb = 0;

  task automatic check(string tag, int actual, int expected);
    vectors++;
    if (actual != expected) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, actual, expected, $time);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 4; i++) mb[i] = 8'h00;
    m_tx = 0; m_rx = 0; m_udf = 0; m_trdy = 0; m_ovr = 0; m_rrdy = 0; m_sb = 0;
  endtask

  task automatic compare_regs(string phase);
    check({phase, " tx_count R2"}, tx_count, m_tx);
    check({phase, " rx_count R9"}, rx_count, m_rx);
    check({phase, " tx_underflow R4 R5"}, tx_underflow, m_udf);
    check({phase, " tx_ready R4 R6"}, tx_ready, m_trdy);
    check({phase, " rx_overrun R7 R10"}, rx_overrun, m_ovr);
    check({phase, " rx_ready R7 R10"}, rx_ready, m_rrdy);
    check({phase, " single_byte R9"}, single_byte, m_sb);
  endtask

  task automatic compare_comb(string phase);
    int exp_tx, exp_rd;
    exp_tx = (m_tx == 0) ? 0 : mb[m_tx-1];
    exp_rd = big_endian ? {mb[0], mb[1]} : {mb[1], mb[0]};
    check({phase, " eng_tx_byte R3 R5"}, eng_tx_byte, exp_tx);
    check({phase, " host_rdata R3 R8"}, host_rdata, exp_rd);
  endtask

  task automatic model_step();
    if (!rst_n || !enable) begin
      model_clear();
    end else if (host_wr) begin
      if (m_tx <= 2) begin
        mb[3] = mb[1]; mb[2] = mb[0];
        mb[1] = big_endian ? host_wdata[15:8] : host_wdata[7:0];
        mb[0] = big_endian ? host_wdata[7:0]  : host_wdata[15:8];
        m_tx += 2;
        m_udf = 0;
        if (m_tx > 2) m_trdy = 0;
      end
    end else if (host_rd) begin
      m_ovr = 0;
      if (m_rx == 1) begin
        m_sb = 1; m_rx = 0;
      end else if (m_rx > 1) begin
        if (m_rx > 2) begin
          mb[0] = mb[2]; mb[1] = mb[3]; mb[2] = 0; mb[3] = 0;
        end
        m_rx -= 2;
      end
      if (m_rx == 0) m_rrdy = 0;
    end else if (eng_tx_pop) begin
      m_trdy = 1;
      if (m_tx == 0) m_udf = 1; else m_tx--;
    end else if (eng_rx_push) begin
      m_rrdy = 1;
      if (m_rx == 4) m_ovr = 1;
      else begin mb[m_rx] = eng_rx_byte; m_rx++; end
    end
  endtask

  // one cycle: outputs sampled at negedge, inputs driven, model advanced
  task automatic cycle(string phase, bit en, bit be, int op, logic [15:0] w, logic [7:0] b);
    @(negedge clk);
    compare_regs(phase);
    enable = en; big_endian = be;
    host_wr = (op == 1); host_rd = (op == 2); eng_tx_pop = (op == 3); eng_rx_push = (op == 4);
    host_wdata = w; eng_rx_byte = b;
    #1;
    compare_comb(phase);
    model_step();
  endtask

  initial begin
    model_clear();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    compare_regs("R1 reset");
    compare_comb("R1 reset");
    rst_n = 1'b1;
    cycle("R1 idle", 1, 0, 0, 0, 0);
    // R3: little order write then pops
    cycle("R3 wr", 1, 0, 1, 16'hA1B2, 0);
    cycle("R2 wr2", 1, 0, 1, 16'hC3D4, 0);
    cycle("R2 wr full", 1, 0, 1, 16'hEEEE, 0);
    cycle("R5 pop", 1, 0, 3, 0, 0);
    cycle("R5 pop", 1, 0, 3, 0, 0);
    cycle("R2 wr at 2", 1, 1, 1, 16'h1234, 0);
    for (int i = 0; i < 5; i++) cycle("R5 drain", 1, 1, 3, 0, 0);
    cycle("R4 wr after udf", 1, 1, 1, 16'h5678, 0);
    // R7 receive fill, overrun, R9 reads
    cycle("R1 disable", 0, 0, 0, 0, 0);
    for (int i = 0; i < 5; i++) cycle("R7 push", 1, 0, 4, 0, 8'h10 + 8'(i));
    cycle("R8 rd", 1, 1, 2, 0, 0);
    cycle("R9 rd", 1, 1, 2, 0, 0);
    cycle("R10 rd empty", 1, 0, 2, 0, 0);
    cycle("R7 push1", 1, 0, 4, 0, 8'h77);
    cycle("R9 single", 1, 0, 2, 0, 0);
    cycle("R9 idle", 1, 0, 0, 0, 0);
    for (int n = 0; n < 3000; n++) begin
      int r = $urandom_range(0, 99);
      bit en = (r != 0);
      int op = $urandom_range(0, 4);
      cycle("rand", en, 1'($urandom_range(0, 1)), op, 16'($urandom), 8'($urandom));
    end
    @(negedge clk);
    compare_regs("final");
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    if (!finished) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule